// File: doc/BRIEF.md
# Down-Counting Periodic Timer with Compare

This peripheral holds a 32-bit counter that moves down by one on each pulse of an internal divided clock enable. It is programmed through four word registers: control, status, load and compare. When the count passes zero it either takes the load value again or rolls over to all-ones, as a mode bit selects. Whenever a decrement lands on the compare value while the timer runs and the compare interrupt is enabled, a sticky status flag is set. The interrupt line is that flag gated by the enable.

Firmware starts the timer by setting the run bit. If the start-load bit is also set on that rising edge, the counter is first filled from the load register, or with all-ones in free-running mode. A soft-reset command returns the registers to their defaults but keeps the run and power-related control bits, so a running timer keeps counting from all-ones. A write to the load register can also overwrite the live count when the pass-through bit is set.

The run/stop sequencing is a two-state machine. STOPPED moves to RUNNING by transition START, which is a control write with the run bit set. RUNNING moves to STOPPED by transition HALT, which is a control write with the run bit clear. Every other write leaves the state as it is.

Top module: `cmp_dntimer`

Control layout, counted from bit 0:

| Bit | Name | Meaning |
|---|---|---|
| 0 | run | timer enable |
| 1 | start-load | fill the counter when the timer starts |
| 2 | compare interrupt enable | |
| 3 | reload mode | 1 reloads from the load register, 0 rolls over to all-ones |
| [15:4] | prescaler | divide by value plus one |
| 16 | soft reset | |
| 17 | load pass-through | |
| [19:18] | clock select | stored only |
| 20 | stop keep | stored only |
| 21 | doze keep | stored only |
| 22 | wait keep | stored only |
| 23 | debug keep | stored only |
| [25:24] | spare | stored only |

## Requirements
- R1: The register index is reg_addr[3:2]: 0 control, 1 status (flag in bit 0), 2 load, 3 compare. Reads return the selected register at once. After reset control is 0, status is 0, load is 0xFFFFFFFF and compare is 0.
- R2: A control write stores only bits [25:0]. Bits [31:26] always read as 0.
- R3: A control write with bit 16 set makes control equal to the written value masked to bits 0, 1, 20, 21, 22 and 23. It also clears status and compare, sets load to 0xFFFFFFFF, sets the counter to 0xFFFFFFFF and restarts the prescaler. Counting continues if bit 0 stays set.
- R4: A control write that takes bit 0 from 0 to 1 with bit 1 set loads the counter from the load register when bit 3 is set, or with 0xFFFFFFFF when bit 3 is clear. A control write while bit 0 is already set never restarts the count.
- R5: While bit 0 is clear the counter holds its value and no compare match occurs.
- R6: While running, the counter decrements once every (bits[15:4] + 1) clock cycles.
- R7: A decrement from 0 loads the load value when bit 3 is set and 0xFFFFFFFF when bit 3 is clear.
- R8: A load write while control bit 17 is set also puts the written value into the counter in the same cycle.
- R9: A decrement whose result equals the compare value, with bits 0 and 2 set, sets the status flag. This includes a compare value of 0.
- R10: Writing status with bit 0 set clears the flag, unless a match sets it in the same cycle. irq equals the flag ANDed with control bit 2.
- R11: Setting bit 2 while the timer runs arms compare detection without changing the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 4 | byte offset of the register |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data of the register at reg_addr |
| irq | output | 1 | compare interrupt |

## Verification
The assertions assume one register write at most per cycle and a reset that starts low before the first edge. The bench keeps to this by driving a single write strobe per step from one task.

The prescaler check assumes the divider field does not drop below the running count of the prescaler. Random stimulus therefore keeps the divider between 0 and 3. It also keeps load and compare below 24, so matches happen often.

Soft resets are rare in the random stream. This lets the small load and compare values stay in force long enough to produce reloads, wraps and flag clears.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W = 32;
    localparam int CTRL_W = 26;
    localparam int PSC_W  = 12;
    localparam int IDX_W  = 2;
    localparam int ADDR_W = IDX_W + 2;

    localparam int BIT_RUN    = 0,
                   BIT_STLD   = 1,
                   BIT_CIE    = 2,
                   BIT_ARLD   = 3,
                   BIT_PSC_LO = 4,
                   BIT_PSC_HI = BIT_PSC_LO + PSC_W - 1,
                   BIT_SRST   = 16,
                   BIT_THRU   = 17;

    // Bits that survive a soft reset: run, start-load and the four power keeps.
    localparam logic [CTRL_W-1:0] KEEP_MASK = 26'h0F0_0003;

    typedef enum logic [IDX_W-1:0] {
        IDX_CTRL = 2'd0,
        IDX_STAT = 2'd1,
        IDX_LOAD = 2'd2,
        IDX_CMP  = 2'd3
    } reg_idx_e;

    typedef enum logic [0:0] {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_W = tmr_pkg::PSC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pre_q;

    assign tick = run && (pre_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || clr || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R6: every tick restarts the division window
    assert_tick_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_q == '0));

    // R5: a stopped timer leaves the divider parked at zero
    assert_idle_parked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_q == '0));
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  reg_idx_e          idx,
    input  logic [DW-1:0]     wdata,
    input  logic              match,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [DW-1:0]     load_q,
    output logic [DW-1:0]     cmp_q,
    output logic              stat_q,
    output logic [DW-1:0]     rdata,
    output logic              ctrl_wr,
    output logic              srst,
    output logic              load_wr
);
    logic stat_wr;
    logic cmp_wr;

    assign ctrl_wr = wr && (idx == IDX_CTRL);
    assign stat_wr = wr && (idx == IDX_STAT);
    assign load_wr = wr && (idx == IDX_LOAD);
    assign cmp_wr  = wr && (idx == IDX_CMP);
    assign srst    = ctrl_wr && wdata[BIT_SRST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (srst) begin
            ctrl_q <= wdata[CTRL_W-1:0] & KEEP_MASK;
        end else if (ctrl_wr) begin
            ctrl_q <= wdata[CTRL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '1;
            cmp_q  <= '0;
        end else if (srst) begin
            load_q <= '1;
            cmp_q  <= '0;
        end else begin
            if (load_wr) load_q <= wdata;
            if (cmp_wr)  cmp_q  <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (srst) begin
            stat_q <= 1'b0;
        end else if (match) begin
            stat_q <= 1'b1;
        end else if (stat_wr && wdata[0]) begin
            stat_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (idx)
            IDX_CTRL: rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            IDX_STAT: rdata = {{(DW-1){1'b0}}, stat_q};
            IDX_LOAD: rdata = load_q;
            IDX_CMP:  rdata = cmp_q;
        endcase
    end

    assert_swr_defaults_R3: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (load_q == '1 && cmp_q == '0 && !stat_q));

    assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !srst) |=> (ctrl_q == $past(wdata[CTRL_W-1:0])));

    assert_match_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !srst) |=> stat_q);

    assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q) |-> $past(match));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ctrl_wr,
    input  logic          srst,
    input  logic          wr_run,
    input  logic          wr_stld,
    input  logic          wr_arld,
    input  logic          load_wr,
    input  logic          load_thru,
    input  logic          cmp_ie,
    input  logic          auto_rld,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] load_q,
    input  logic [DW-1:0] cmp_q,
    output logic          running,
    output logic          match
);
    run_state_e state_q, state_d;
    logic       start_evt;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] cnt_dec;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // next state: START and HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (ctrl_wr && wr_run)  state_d = ST_RUNNING;
            ST_RUNNING: if (ctrl_wr && !wr_run) state_d = ST_STOPPED;
        endcase
    end

    // state outputs
    always_comb begin
        running   = 1'b0;
        start_evt = 1'b0;
        unique case (state_q)
            ST_STOPPED: start_evt = ctrl_wr && wr_run;
            ST_RUNNING: running   = 1'b1;
        endcase
    end

    assign cnt_dec = (cnt_q == '0) ? (auto_rld ? load_q : '1) : (cnt_q - 1'b1);
    assign match   = tick && cmp_ie && (cnt_dec == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (srst) begin
            cnt_q <= '1;
        end else if (start_evt && wr_stld) begin
            cnt_q <= wr_arld ? load_q : '1;
        end else if (load_wr && load_thru) begin
            cnt_q <= wdata;
        end else if (tick) begin
            cnt_q <= cnt_dec;
        end
    end

    assert_stopped_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && !ctrl_wr && !(load_wr && load_thru)) |=> (cnt_q == $past(cnt_q)));

    assert_no_match_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED) |-> !match);

    assert_wrap_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == '0 && !auto_rld && !ctrl_wr && !load_wr) |=> (cnt_q == '1));

    assert_thru_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_wr && load_thru) |=> (cnt_q == $past(wdata)));

    assert_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUNNING && ctrl_wr && !srst && !tick) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/cmp_dntimer.sv
module cmp_dntimer
    import tmr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [DW-1:0]     load_q;
    logic [DW-1:0]     cmp_q;
    logic              stat_q;
    logic              ctrl_wr, srst, load_wr;
    logic              running, match, tick;
    logic              unused_addr_lo;
    reg_idx_e          idx;

    assign idx            = reg_idx_e'(reg_addr[AW-1:2]);
    assign unused_addr_lo = ^reg_addr[1:0];

    tmr_regfile #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .idx     (idx),
        .wdata   (reg_wdata),
        .match   (match),
        .ctrl_q  (ctrl_q),
        .load_q  (load_q),
        .cmp_q   (cmp_q),
        .stat_q  (stat_q),
        .rdata   (reg_rdata),
        .ctrl_wr (ctrl_wr),
        .srst    (srst),
        .load_wr (load_wr)
    );

    tmr_prescale #(.DIV_W(PSC_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .clr   (srst),
        .div   (ctrl_q[BIT_PSC_HI:BIT_PSC_LO]),
        .tick  (tick)
    );

    tmr_core #(.DW(DW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ctrl_wr   (ctrl_wr),
        .srst      (srst),
        .wr_run    (reg_wdata[BIT_RUN]),
        .wr_stld   (reg_wdata[BIT_STLD]),
        .wr_arld   (reg_wdata[BIT_ARLD]),
        .load_wr   (load_wr),
        .load_thru (ctrl_q[BIT_THRU]),
        .cmp_ie    (ctrl_q[BIT_CIE]),
        .auto_rld  (ctrl_q[BIT_ARLD]),
        .wdata     (reg_wdata),
        .load_q    (load_q),
        .cmp_q     (cmp_q),
        .running   (running),
        .match     (match)
    );

    assign irq = stat_q && ctrl_q[BIT_CIE];

    // R4: the run state machine and the stored run bit never disagree
    assert_state_tracks_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        running == ctrl_q[BIT_RUN]);
endmodule

// File: tb/sim_cmp_dntimer.sv
`timescale 1ns/1ps
module sim_cmp_dntimer;
    localparam real HALF = 2.5;
    localparam logic [25:0] KEEP = 26'h0F0_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    logic [25:0] m_ctrl;
    logic [31:0] m_load, m_cmp, m_cnt;
    logic        m_stat;
    logic [11:0] m_pre;

    cmp_dntimer u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(HALF) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [1:0] i);
        case (i)
            2'd0:    return {6'd0, m_ctrl};
            2'd1:    return {31'd0, m_stat};
            2'd2:    return m_load;
            default: return m_cmp;
        endcase
    endfunction

    // one clock of stimulus; model follows the requirements
    task automatic step(input bit we, input logic [3:0] a, input logic [31:0] d);
        logic run, tk, mt;
        logic [31:0] dec;
        logic [25:0] n_ctrl;
        logic [31:0] n_load, n_cmp, n_cnt;
        logic        n_stat;
        logic [11:0] n_pre;
        @(negedge clk);
        reg_wr = we; reg_addr = a; reg_wdata = d;
        run = m_ctrl[0];
        tk  = run && (m_pre >= m_ctrl[15:4]);                    // R6
        dec = (m_cnt == 0) ? (m_ctrl[3] ? m_load : 32'hFFFF_FFFF) : m_cnt - 1; // R7
        mt  = tk && m_ctrl[2] && (dec == m_cmp);                 // R9
        n_ctrl = m_ctrl; n_load = m_load; n_cmp = m_cmp; n_stat = m_stat;
        n_pre = (!run || tk) ? 12'd0 : m_pre + 12'd1;
        n_cnt = tk ? dec : m_cnt;
        if (mt) n_stat = 1'b1;
        if (we) begin
            case (a[3:2])
                2'd0: if (d[16]) begin                           // R3
                          n_ctrl = d[25:0] & KEEP; n_load = '1; n_cmp = '0;
                          n_stat = 1'b0; n_cnt = '1; n_pre = '0;
                      end else begin
                          n_ctrl = d[25:0];                      // R2
                          if (!run && d[0] && d[1]) n_cnt = d[3] ? m_load : '1; // R4
                      end
                2'd1: if (d[0] && !mt) n_stat = 1'b0;            // R10
                2'd2: begin n_load = d; if (m_ctrl[17]) n_cnt = d; end // R8
                default: n_cmp = d;
            endcase
        end
        @(posedge clk);
        m_ctrl = n_ctrl; m_load = n_load; m_cmp = n_cmp; m_stat = n_stat;
        m_cnt = n_cnt; m_pre = n_pre;
        #1;
        chk("R10 irq", {31'd0, irq}, {31'd0, m_stat & m_ctrl[2]});
        chk("R1 read", reg_rdata, m_read(a[3:2]));
        reg_wr = 1'b0;
    endtask

    task automatic wait_irq(input int maxn, output int n);
        n = 0;
        while (!irq && n < maxn) begin
            step(1'b0, 4'h4, 32'd0);
            n++;
        end
    endtask

    task automatic rd(input logic [3:0] a, input string req, input logic [31:0] exp);
        step(1'b0, a, 32'd0);
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        #(HALF * 2 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd2024);
        m_ctrl = '0; m_load = '1; m_cmp = '0; m_cnt = '1; m_stat = 1'b0; m_pre = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset values
        rd(4'h0, "R1 ctrl reset", 32'h0);
        rd(4'h4, "R1 stat reset", 32'h0);
        rd(4'h8, "R1 load reset", 32'hFFFF_FFFF);
        rd(4'hC, "R1 cmp reset",  32'h0);
        chk("R1 irq reset", {31'd0, irq}, 32'd0);

        // R2 control width
        step(1'b1, 4'h0, 32'hFFFE_FFF0);
        chk("R2 ctrl mask", reg_rdata, 32'h03FE_FFF0);
        step(1'b1, 4'h0, 32'h0);

        // R4 start-load, R9 match
        step(1'b1, 4'h8, 32'd5);
        step(1'b1, 4'hC, 32'd2);
        step(1'b1, 4'h0, 32'h0000_000F);
        wait_irq(50, n); chk("R4 R9 first match", n, 3);
        step(1'b1, 4'h4, 32'd1);
        chk("R10 flag clear", {31'd0, irq}, 32'd0);
        wait_irq(50, n); chk("R7 reload period", n, 5);

        // R6 prescaler, then R5 stop
        step(1'b1, 4'h0, 32'h0);
        step(1'b1, 4'h4, 32'd1);
        step(1'b1, 4'h0, 32'h0000_003F);
        wait_irq(80, n); chk("R6 divide by four", n, 12);
        step(1'b1, 4'h4, 32'd1);
        step(1'b1, 4'h0, 32'h0000_003E);
        wait_irq(40, n); chk("R5 no match stopped", n, 40);
        rd(4'h4, "R5 status stays clear", 32'd0);

        // R7 roll-over to all-ones, R4 no restart while running
        step(1'b1, 4'h8, 32'd2);
        step(1'b1, 4'hC, 32'hFFFF_FFFF);
        step(1'b1, 4'h0, 32'h0000_000F);
        step(1'b1, 4'h0, 32'h0000_0007);
        wait_irq(50, n); chk("R7 R4 wrap without restart", n, 2);

        // R8 pass-through load
        step(1'b1, 4'h0, 32'h0);
        step(1'b1, 4'h4, 32'd1);
        step(1'b1, 4'hC, 32'd7);
        step(1'b1, 4'h0, 32'h0002_000D);
        step(1'b1, 4'h8, 32'd9);
        wait_irq(50, n); chk("R8 load overwrites count", n, 2);

        // R9 compare value zero
        step(1'b1, 4'h0, 32'h0);
        step(1'b1, 4'h4, 32'd1);
        step(1'b1, 4'h8, 32'd3);
        step(1'b1, 4'hC, 32'd0);
        step(1'b1, 4'h0, 32'h0000_000F);
        wait_irq(50, n); chk("R9 compare zero", n, 3);

        // R11 arm compare while running
        step(1'b1, 4'h0, 32'h0);
        step(1'b1, 4'h4, 32'd1);
        step(1'b1, 4'h8, 32'd9);
        step(1'b1, 4'hC, 32'd4);
        step(1'b1, 4'h0, 32'h0000_000B);
        step(1'b1, 4'h0, 32'h0000_000F);
        wait_irq(50, n); chk("R11 arm keeps count", n, 4);

        // R10 gating and clear
        step(1'b1, 4'h0, 32'h0000_000B);
        chk("R10 irq gated", {31'd0, irq}, 32'd0);
        rd(4'h4, "R10 flag kept", 32'd1);
        step(1'b1, 4'h4, 32'd0);
        chk("R10 zero write ignored", reg_rdata, 32'd1);
        step(1'b1, 4'h4, 32'd1);
        chk("R10 one write clears", reg_rdata, 32'd0);

        // R3 soft reset while running
        step(1'b1, 4'h0, 32'h0021_00FF);
        rd(4'h0, "R3 ctrl kept bits", 32'h0020_0003);
        rd(4'h4, "R3 status cleared", 32'd0);
        rd(4'h8, "R3 load ones", 32'hFFFF_FFFF);
        rd(4'hC, "R3 cmp cleared", 32'd0);
        step(1'b1, 4'h0, 32'h0000_0007);
        step(1'b1, 4'hC, 32'hFFFF_FFF0);
        wait_irq(50, n); chk("R3 counting continues from ones", n, 9);

        // constrained random mix, checked every cycle against the model
        for (int i = 0; i < 5000; i++) begin
            logic [31:0] d;
            logic [3:0]  a;
            a = {$urandom_range(3, 0)}[1:0] << 2;
            d = $urandom;
            if ($urandom_range(9, 0) < 3) begin
                case (a[3:2])
                    2'd0: begin
                        d[0]     = ($urandom_range(3, 0) != 0);
                        d[3]     = ($urandom_range(3, 0) != 0);
                        d[15:4]  = 12'($urandom_range(3, 0));
                        d[16]    = ($urandom_range(39, 0) == 0);
                    end
                    2'd2, 2'd3: d = $urandom_range(23, 0);
                    default: ;
                endcase
                step(1'b1, a, d);
            end else begin
                step(1'b0, a, d);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule